// File: doc/BRIEF.md
# Indexed Register Access Window

This block is the device-side register file of a display controller, reached by the host through a small I/O aperture. The host side is a single 32-bit port with separate read and write strobes and an 8-bit aperture offset. The low part of the register space sits in the aperture and is decoded directly. Registers at offset 0x100 and above are reached indirectly: the host first writes the full target offset into an index register, then reads or writes a data register.

The file holds nine 32-bit registers:
- a general scan-out control word at 0x50;
- an extended scan-out control word at 0x54;
- three GPIO words for the monitor-identification and display-data-channel lines, at 0x60, 0x64 and 0x68;
- four timing and layout words: horizontal timing at 0x200, vertical timing at 0x208, start offset at 0x224 and line pitch at 0x22C.

Every register drives an output port. The fields that downstream scan-out logic needs most are also broken out as separate ports: the pixel-format code, the CRTC enable, the external display enable, the display-off bit and the CRTC power-on bit.

Reads are combinational from the stored state. When a read and a write hit the same register in one cycle, the read returns the value held before that write.

Top module: `regwin_top`

## Requirements
- R1: After synchronous reset every register, the index register and every output port are zero. This leaves the pixel format at 0 and the display disabled.
- R2: A write at aperture offset 0x50, 0x54, 0x60, 0x64 or 0x68 updates the register at that offset on the clock edge. A read at the same offset then returns the stored 32-bit value, and the matching output port shows it from the next cycle.
- R3: A write at aperture offset 0x0 stores all 32 bits of wdata in the index register, and a read at offset 0x0 returns the last value written there.
- R4: An access at aperture offset 0x4 reaches the register whose offset is held in the index register. The horizontal timing, vertical timing, start offset and pitch registers (0x200, 0x208, 0x224, 0x22C) are reached this way.
- R5: An index value below 0x100 that names a directly mapped register (for example 0x64) makes the data window alias that same register. Index values 0x0 and 0x4 name no register through the window: a write there changes neither the index nor any register.
- R6: A read of an unmapped offset returns zero, and a write to it changes no register, whether the offset is direct (for example 0x58) or indirect (for example 0x300). Offsets that are not a multiple of 4 count as unmapped.
- R7: The field ports decode the two control words. pix_fmt_o is bits 10:8 of the general control word, with codes 1=4, 2=8, 3=15, 4=16, 5=24 and 6=32 bits per pixel. crtc_en_o is bit 25 and ext_disp_en_o is bit 24 of that word. disp_off_o is bit 10 and crtc_on_o is bit 15 of the extended control word.
- R8: When rd_en and wr_en are both high for the same offset, rdata carries the value held before the edge, and the new value is visible from the next cycle.
- R9: rdata is zero whenever rd_en is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the current offset |
| rd_en | input | 1 | Read strobe for the current offset |
| addr | input | 8 | Aperture offset in bytes |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, combinational |
| gen_ctrl_o | output | 32 | General scan-out control word (0x50) |
| ext_ctrl_o | output | 32 | Extended scan-out control word (0x54) |
| ddc_a_o | output | 32 | First display-data-channel GPIO word (0x60) |
| ddc_b_o | output | 32 | Second display-data-channel GPIO word (0x64) |
| mon_id_o | output | 32 | Monitor-identification GPIO word (0x68) |
| h_timing_o | output | 32 | Horizontal total/display word (0x200) |
| v_timing_o | output | 32 | Vertical total/display word (0x208) |
| start_o | output | 32 | Scan-out start offset (0x224) |
| pitch_o | output | 32 | Line pitch (0x22C) |
| pix_fmt_o | output | 3 | Pixel-format code |
| crtc_en_o | output | 1 | CRTC enable |
| ext_disp_en_o | output | 1 | External display enable |
| disp_off_o | output | 1 | Display-off request |
| crtc_on_o | output | 1 | CRTC power-on |

## Verification
A read and a write can land on the same register in the same cycle. The bench provokes this by raising both strobes for the extended control word, with a new value on wdata. Before the edge, the bench requires rdata to show the old contents. After the edge, it requires a plain read and the disp_off_o port to show the new contents. The same collision on the index register is covered by an assertion that compares rdata with the stored index during a write to offset 0x0.

// File: rtl/regwin_pkg.sv
package regwin_pkg;

    localparam int DW   = 32;
    localparam int APW  = 8;
    localparam int NREG = 9;

    localparam logic [APW-1:0] INDEX_OFF = 8'h00;
    localparam logic [APW-1:0] DATA_OFF  = 8'h04;

    typedef enum int {
        RG_GEN   = 0,
        RG_EXT   = 1,
        RG_DDCA  = 2,
        RG_DDCB  = 3,
        RG_MONID = 4,
        RG_HTIM  = 5,
        RG_VTIM  = 6,
        RG_START = 7,
        RG_PITCH = 8
    } reg_id_e;

    typedef enum logic [2:0] {
        PF_NONE = 3'd0,
        PF_4    = 3'd1,
        PF_8    = 3'd2,
        PF_15   = 3'd3,
        PF_16   = 3'd4,
        PF_24   = 3'd5,
        PF_32   = 3'd6
    } pix_fmt_e;

    typedef struct packed {
        pix_fmt_e pix_fmt;
        logic     crtc_en;
        logic     ext_disp_en;
        logic     disp_off;
        logic     crtc_on;
    } ctrl_fields_t;

    function automatic logic [DW-1:0] reg_off(input int id);
        case (id)
            RG_GEN:   reg_off = 32'h0000_0050;
            RG_EXT:   reg_off = 32'h0000_0054;
            RG_DDCA:  reg_off = 32'h0000_0060;
            RG_DDCB:  reg_off = 32'h0000_0064;
            RG_MONID: reg_off = 32'h0000_0068;
            RG_HTIM:  reg_off = 32'h0000_0200;
            RG_VTIM:  reg_off = 32'h0000_0208;
            RG_START: reg_off = 32'h0000_0224;
            RG_PITCH: reg_off = 32'h0000_022C;
            default:  reg_off = 32'hFFFF_FFFF;
        endcase
    endfunction

    function automatic ctrl_fields_t split_ctrl(input logic [DW-1:0] gen,
                                                input logic [DW-1:0] ext);
        ctrl_fields_t f;
        f.pix_fmt     = pix_fmt_e'(gen[10:8]);
        f.crtc_en     = gen[25];
        f.ext_disp_en = gen[24];
        f.disp_off    = ext[10];
        f.crtc_on     = ext[15];
        return f;
    endfunction

endpackage

// File: rtl/regwin_decode.sv
module regwin_decode
    import regwin_pkg::*;
#(
    parameter int W = DW,
    parameter int N = NREG
) (
    input  logic [W-1:0] off,
    output logic [N-1:0] hit
);
    for (genvar i = 0; i < N; i++) begin : g_cmp
        localparam logic [W-1:0] MATCH = W'(reg_off(i));
        assign hit[i] = (off == MATCH);
    end
endmodule

// File: rtl/regwin_bank.sv
module regwin_bank
    import regwin_pkg::*;
#(
    parameter int W = DW,
    parameter int N = NREG
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [N-1:0]      hit,
    input  logic [W-1:0]      wdata,
    output logic [N-1:0][W-1:0] store,
    output logic [W-1:0]      rd_val
);
    for (genvar i = 0; i < N; i++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst)
                store[i] <= '0;
            else if (we && hit[i])
                store[i] <= wdata;
        end

        // R2
        wr_capture_chk: assert property (@(posedge clk) disable iff (rst)
            (we && hit[i]) |=> (store[i] == $past(wdata)));
    end

    always_comb begin
        rd_val = '0;
        for (int i = 0; i < N; i++)
            rd_val |= store[i] & {W{hit[i]}};
    end

    // R6
    stray_write_chk: assert property (@(posedge clk) disable iff (rst)
        (hit == '0) |=> $stable(store));
endmodule

// File: rtl/regwin_top.sv
module regwin_top
    import regwin_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic        rd_en,
    input  logic [7:0]  addr,
    input  logic [31:0] wdata,
    output logic [31:0] rdata,
    output logic [31:0] gen_ctrl_o,
    output logic [31:0] ext_ctrl_o,
    output logic [31:0] ddc_a_o,
    output logic [31:0] ddc_b_o,
    output logic [31:0] mon_id_o,
    output logic [31:0] h_timing_o,
    output logic [31:0] v_timing_o,
    output logic [31:0] start_o,
    output logic [31:0] pitch_o,
    output logic [2:0]  pix_fmt_o,
    output logic        crtc_en_o,
    output logic        ext_disp_en_o,
    output logic        disp_off_o,
    output logic        crtc_on_o
);
    localparam int PAD = DW - APW;

    logic [DW-1:0]            index_q;
    logic [DW-1:0]            eff_off;
    logic                     sel_index;
    logic                     sel_data;
    logic [NREG-1:0]          hit;
    logic [NREG-1:0][DW-1:0]  store;
    logic [DW-1:0]            bank_val;
    ctrl_fields_t             fld;

    assign sel_index = (addr == INDEX_OFF);
    assign sel_data  = (addr == DATA_OFF);
    assign eff_off   = sel_data ? index_q : {{PAD{1'b0}}, addr};

    always_ff @(posedge clk) begin
        if (rst)
            index_q <= '0;
        else if (wr_en && sel_index)
            index_q <= wdata;
    end

    regwin_decode #(.W(DW), .N(NREG)) u_dec (
        .off (eff_off),
        .hit (hit)
    );

    regwin_bank #(.W(DW), .N(NREG)) u_bank (
        .clk    (clk),
        .rst    (rst),
        .we     (wr_en && !sel_index),
        .hit    (hit),
        .wdata  (wdata),
        .store  (store),
        .rd_val (bank_val)
    );

    always_comb begin
        rdata = '0;
        if (rd_en)
            rdata = sel_index ? index_q : bank_val;
    end

    assign gen_ctrl_o = store[RG_GEN];
    assign ext_ctrl_o = store[RG_EXT];
    assign ddc_a_o    = store[RG_DDCA];
    assign ddc_b_o    = store[RG_DDCB];
    assign mon_id_o   = store[RG_MONID];
    assign h_timing_o = store[RG_HTIM];
    assign v_timing_o = store[RG_VTIM];
    assign start_o    = store[RG_START];
    assign pitch_o    = store[RG_PITCH];

    assign fld           = split_ctrl(store[RG_GEN], store[RG_EXT]);
    assign pix_fmt_o     = fld.pix_fmt;
    assign crtc_en_o     = fld.crtc_en;
    assign ext_disp_en_o = fld.ext_disp_en;
    assign disp_off_o    = fld.disp_off;
    assign crtc_on_o     = fld.crtc_on;

    // R1
    reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (index_q == '0 && gen_ctrl_o == '0 && ext_ctrl_o == '0));

    // R3
    index_load_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && sel_index) |=> (index_q == $past(wdata)));

    // R8
    index_collide_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_en && wr_en && sel_index) |-> (rdata == index_q));

    // R5
    window_no_index_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && sel_data) |=> $stable(index_q));
endmodule

// File: tb/tb_regwin_top.sv
module tb_regwin_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [7:0]  addr = 8'h00;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [31:0] gen_ctrl_o, ext_ctrl_o, ddc_a_o, ddc_b_o, mon_id_o;
    logic [31:0] h_timing_o, v_timing_o, start_o, pitch_o;
    logic [2:0]  pix_fmt_o;
    logic        crtc_en_o, ext_disp_en_o, disp_off_o, crtc_on_o;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    regwin_top dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata),
        .gen_ctrl_o(gen_ctrl_o), .ext_ctrl_o(ext_ctrl_o),
        .ddc_a_o(ddc_a_o), .ddc_b_o(ddc_b_o), .mon_id_o(mon_id_o),
        .h_timing_o(h_timing_o), .v_timing_o(v_timing_o),
        .start_o(start_o), .pitch_o(pitch_o),
        .pix_fmt_o(pix_fmt_o), .crtc_en_o(crtc_en_o),
        .ext_disp_en_o(ext_disp_en_o), .disp_off_o(disp_off_o),
        .crtc_on_o(crtc_on_o)
    );

    typedef struct packed {
        logic        wr;
        logic        rd;
        logic [7:0]  a;
        logic [31:0] wd;
        logic [31:0] ex;
    } vec_t;

    localparam int NV = 33;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 1'b1, 8'h50, 32'h0,          32'h0},          // R1 reset value
        '{1'b1, 1'b0, 8'h50, 32'h0300_0600,  32'h0},          // R2
        '{1'b0, 1'b1, 8'h50, 32'h0,          32'h0300_0600},  // R2
        '{1'b1, 1'b0, 8'h54, 32'h0000_8000,  32'h0},          // R2
        '{1'b0, 1'b1, 8'h54, 32'h0,          32'h0000_8000},  // R2
        '{1'b1, 1'b0, 8'h60, 32'h0003_0000,  32'h0},          // R2
        '{1'b0, 1'b1, 8'h60, 32'h0,          32'h0003_0000},  // R2
        '{1'b1, 1'b0, 8'h00, 32'h0000_0200,  32'h0},          // R3
        '{1'b0, 1'b1, 8'h00, 32'h0,          32'h0000_0200},  // R3
        '{1'b1, 1'b0, 8'h04, 32'h004F_0000,  32'h0},          // R4 horizontal
        '{1'b0, 1'b1, 8'h04, 32'h0,          32'h004F_0000},  // R4
        '{1'b1, 1'b0, 8'h00, 32'h0000_022C,  32'h0},          // R4
        '{1'b1, 1'b0, 8'h04, 32'h0000_0050,  32'h0},          // R4 pitch
        '{1'b0, 1'b1, 8'h04, 32'h0,          32'h0000_0050},  // R4
        '{1'b1, 1'b0, 8'h00, 32'h0000_0064,  32'h0},          // R5 alias
        '{1'b1, 1'b0, 8'h04, 32'h0002_0000,  32'h0},          // R5
        '{1'b0, 1'b1, 8'h64, 32'h0,          32'h0002_0000},  // R5
        '{1'b1, 1'b0, 8'h00, 32'h0000_0004,  32'h0},          // R5 window on itself
        '{1'b1, 1'b0, 8'h04, 32'h0000_1234,  32'h0},          // R5
        '{1'b0, 1'b1, 8'h00, 32'h0,          32'h0000_0004},  // R5 index kept
        '{1'b0, 1'b1, 8'h04, 32'h0,          32'h0},          // R5 reads zero
        '{1'b1, 1'b0, 8'h00, 32'h0000_0300,  32'h0},          // R6 unmapped indirect
        '{1'b1, 1'b0, 8'h04, 32'hDEAD_BEEF,  32'h0},          // R6
        '{1'b0, 1'b1, 8'h04, 32'h0,          32'h0},          // R6
        '{1'b1, 1'b0, 8'h58, 32'hFFFF_FFFF,  32'h0},          // R6 unmapped direct
        '{1'b0, 1'b1, 8'h58, 32'h0,          32'h0},          // R6
        '{1'b1, 1'b0, 8'h51, 32'hFFFF_FFFF,  32'h0},          // R6 misaligned
        '{1'b0, 1'b1, 8'h50, 32'h0,          32'h0300_0600},  // R6 untouched
        '{1'b1, 1'b0, 8'h00, 32'h0000_0201,  32'h0},          // R6 misaligned index
        '{1'b1, 1'b0, 8'h04, 32'h5555_5555,  32'h0},          // R6
        '{1'b1, 1'b0, 8'h00, 32'h0000_0200,  32'h0},          // R6
        '{1'b0, 1'b1, 8'h04, 32'h0,          32'h004F_0000},  // R6 untouched
        '{1'b0, 1'b1, 8'h68, 32'h0,          32'h0}           // R6 untouched
    };

    task automatic check(input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic drive(input logic w, input logic r, input logic [7:0] a,
                         input logic [31:0] d);
        @(negedge clk);
        wr_en = w; rd_en = r; addr = a; wdata = d;
        #2;
    endtask

    task automatic idle();
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1 reset state at the ports
        #2;
        check("R1 gen_ctrl_o", gen_ctrl_o, 32'h0);
        check("R1 pitch_o", pitch_o, 32'h0);
        check("R1 crtc_en_o", {31'h0, crtc_en_o}, 32'h0);

        for (int i = 0; i < NV; i++) begin
            drive(VEC[i].wr, VEC[i].rd, VEC[i].a, VEC[i].wd);
            if (VEC[i].rd)
                check($sformatf("vector %0d rdata", i), rdata, VEC[i].ex);
        end
        idle();
        #2;

        // R7 field decode
        check("R7 pix_fmt_o", {29'h0, pix_fmt_o}, 32'd6);
        check("R7 crtc_en_o", {31'h0, crtc_en_o}, 32'd1);
        check("R7 ext_disp_en_o", {31'h0, ext_disp_en_o}, 32'd1);
        check("R7 crtc_on_o", {31'h0, crtc_on_o}, 32'd1);
        check("R7 disp_off_o", {31'h0, disp_off_o}, 32'd0);

        // R2, R4 and R6 register ports
        check("R2 ddc_a_o", ddc_a_o, 32'h0003_0000);
        check("R5 ddc_b_o", ddc_b_o, 32'h0002_0000);
        check("R4 h_timing_o", h_timing_o, 32'h004F_0000);
        check("R4 pitch_o", pitch_o, 32'h0000_0050);
        check("R6 v_timing_o", v_timing_o, 32'h0);
        check("R6 start_o", start_o, 32'h0);
        check("R6 mon_id_o", mon_id_o, 32'h0);

        // R8 read and write colliding on 0x54
        drive(1'b1, 1'b1, 8'h54, 32'h0000_0400);
        check("R8 old value", rdata, 32'h0000_8000);
        drive(1'b0, 1'b1, 8'h54, 32'h0);
        check("R8 new value", rdata, 32'h0000_0400);
        check("R8 disp_off_o", {31'h0, disp_off_o}, 32'd1);
        check("R8 crtc_on_o", {31'h0, crtc_on_o}, 32'd0);

        // R9 no strobe, no data
        drive(1'b0, 1'b0, 8'h50, 32'h0);
        check("R9 idle rdata", rdata, 32'h0);

        // R1 reset again
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        #2;
        check("R1 gen_ctrl_o after reset", gen_ctrl_o, 32'h0);
        check("R1 h_timing_o after reset", h_timing_o, 32'h0);
        check("R1 disp_off_o after reset", {31'h0, disp_off_o}, 32'h0);
        drive(1'b0, 1'b1, 8'h00, 32'h0);
        check("R1 index after reset", rdata, 32'h0);
        idle();

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule